// File: doc/BRIEF.md
# Vector Register Upper-Half State Tracker

This block holds a file of wide vector registers, each made of a lower and an upper 128-bit half. It also tracks whether the upper halves are clean, live or parked in a shadow buffer. Each operation arrives with a class: narrow legacy, narrow VEX, wide VEX, upper-zeroing or full-zeroing. It also carries a destination index and 256 bits of write data. A three-state tracker decides whether the operation first needs the upper halves of all registers saved to the shadow buffer or brought back from it. When it does, the block holds `op_ready_o` low for a fixed penalty count. The operation commits on the cycle the stall ends.

The block is used to model the cost of mixing narrow legacy code with wide vector code. Only the two explicit zeroing classes return the tracker to the clean state. A combinational read port exposes any register. Debug outputs report the tracker state and the total number of stall cycles since reset.

Top module: `vec_upper_tracker`

## Requirements
- R1: After reset, `dbg_state_o` is 0 (clean) and `dbg_penalty_cnt_o` is 0. Every register reads as zero and `op_ready_o` is high. The state encoding is clean=0, dirty=1, parked=2, and no other value ever appears.
- R2: A wide VEX operation (class 2) writes all 256 bits of the destination. Its result reads back as `{upper, lower}` = `op_data_i`, and the state becomes dirty.
- R3: A narrow legacy operation (class 0) issued in the dirty state holds ready low for exactly PENALTY cycles and then commits. At commit it copies every upper half to the shadow buffer, clears the live upper halves so they read as zero, writes only the destination's lower half, and moves the state to parked.
- R4: A narrow legacy operation in the clean or parked state commits without a stall. It writes only the destination's lower half and changes neither the upper half nor the state.
- R5: A narrow VEX operation (class 1) in the clean or dirty state commits without a stall. It writes the destination's lower half, zeroes its upper half and keeps the state.
- R6: A narrow or wide VEX operation in the parked state stalls for PENALTY cycles. It then restores every upper half from the shadow buffer, applies its own write and moves the state to dirty.
- R7: An upper-zeroing operation (class 3) clears the upper halves of all registers, keeps the lower halves and moves the state to clean. It does not stall when issued in the clean or dirty state.
- R8: A full-zeroing operation (class 4) clears all 256 bits of every register and moves the state to clean. It does not stall when issued in the clean or dirty state.
- R9: An upper-zeroing or full-zeroing operation issued in the parked state stalls for PENALTY cycles before it commits.
- R10: Writing zeros into upper halves through ordinary operations never changes the state. In particular, a wide write with a zero upper half leaves the tracker dirty.
- R11: `dbg_penalty_cnt_o` increases by one for every cycle in which `op_valid_i` is high and `op_ready_o` is low.
- R12: An operation commits on a rising edge where `op_valid_i` and `op_ready_o` are both high. An operation that needs no penalty commits at the first edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present |
| op_ready_o | output | 1 | Operation may commit this cycle |
| op_class_i | input | 3 | 0 narrow legacy, 1 narrow VEX, 2 wide VEX, 3 zero upper, 4 zero all |
| op_dst_i | input | 4 | Destination register index |
| op_data_i | input | 256 | Write data, upper half in bits 255:128 |
| rd_idx_i | input | 4 | Read port register index |
| rd_data_o | output | 256 | Read port data `{upper, lower}` |
| dbg_state_o | output | 2 | Tracker state: 0 clean, 1 dirty, 2 parked |
| dbg_penalty_cnt_o | output | 32 | Total stall cycles since reset |

## Verification
The assertions assume that once an operation is presented with ready low, valid, class, destination and data stay unchanged until the commit edge. They also assume that only class codes 0 to 4 are used. The bench drives each operation at a falling edge and keeps it there until it sees ready high. It drops valid only after the commit edge, and it draws classes only from the legal range. A mixture of directed transitions and random class sequences visits every state and class pair. The random sequences are checked against a bench model of the registers, the shadow buffer and the state.

// File: rtl/vut_pkg.sv
package vut_pkg;

  typedef enum logic [2:0] {
    OP_LEG128 = 3'd0,
    OP_VEX128 = 3'd1,
    OP_VEX256 = 3'd2,
    OP_ZUP    = 3'd3,
    OP_ZALL   = 3'd4
  } op_cls_e;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_DIRTY  = 2'd1,
    ST_PARKED = 2'd2
  } ust_e;

endpackage

// File: rtl/vut_ctrl.sv
module vut_ctrl
  import vut_pkg::*;
#(
  parameter int unsigned PENALTY = 70,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  op_cls_e          cls_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             save_o,
  output logic             restore_o,
  output ust_e             state_o,
  output logic [CNT_W-1:0] pen_cnt_o
);

  localparam int unsigned STALL_W = (PENALTY < 2) ? 1 : $clog2(PENALTY + 1);

  ust_e               state_q, state_d;
  logic [STALL_W-1:0] stall_q;
  logic               granted_q;
  logic [CNT_W-1:0]   pen_q;
  logic               needs_pen;
  logic               is_vex;
  logic               is_zero;

  assign is_vex  = (cls_i == OP_VEX128) || (cls_i == OP_VEX256);
  assign is_zero = (cls_i == OP_ZUP) || (cls_i == OP_ZALL);

  always_comb begin
    unique case (state_q)
      ST_DIRTY:  needs_pen = (cls_i == OP_LEG128);
      ST_PARKED: needs_pen = is_vex || is_zero;
      default:   needs_pen = 1'b0;
    endcase
  end

  // the granted flag lets the same op through once its stall has run out
  assign ready_o   = (stall_q == '0) && (granted_q || !(valid_i && needs_pen));
  assign accept_o  = valid_i && ready_o;
  assign save_o    = accept_o && (state_q == ST_DIRTY) && (cls_i == OP_LEG128);
  assign restore_o = accept_o && (state_q == ST_PARKED) && is_vex;
  assign state_o   = state_q;
  assign pen_cnt_o = pen_q;

  always_comb begin
    state_d = state_q;
    if (accept_o) begin
      unique case (cls_i)
        OP_LEG128: if (state_q == ST_DIRTY) state_d = ST_PARKED;
        OP_VEX128: if (state_q == ST_PARKED) state_d = ST_DIRTY;
        OP_VEX256: state_d = ST_DIRTY;
        OP_ZUP,
        OP_ZALL:   state_d = ST_CLEAN;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CLEAN;
      stall_q   <= '0;
      granted_q <= 1'b0;
      pen_q     <= '0;
    end else begin
      state_q <= state_d;
      if (valid_i && !ready_o) pen_q <= pen_q + CNT_W'(1);
      if (accept_o) begin
        granted_q <= 1'b0;
      end else if (stall_q != '0) begin
        stall_q <= stall_q - STALL_W'(1);
        if (stall_q == STALL_W'(1)) granted_q <= 1'b1;
      end else if (valid_i && needs_pen && !granted_q) begin
        if (PENALTY <= 1) granted_q <= 1'b1;
        else              stall_q   <= STALL_W'(PENALTY - 1);
      end
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3); // R1
  AST_HOLD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_o |=> valid_i && $stable(cls_i)); // R12
  AST_CLEAN_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CLEAN |-> ready_o); // R4
  AST_DIRTY_VEX_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DIRTY && cls_i != OP_LEG128 |-> ready_o); // R5
  AST_WIDE_TO_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && cls_i == OP_VEX256 |=> state_q == ST_DIRTY); // R2
  AST_ZERO_TO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && is_zero |=> state_q == ST_CLEAN); // R7
  AST_PARK_VIA_LEGACY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_PARKED ##1 state_q == ST_PARKED |-> $past(save_o)); // R3

endmodule

// File: rtl/vut_regfile.sv
module vut_regfile
  import vut_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned HALF_W   = 128,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  op_cls_e             cls_i,
  input  logic [IDX_W-1:0]    dst_i,
  input  logic [2*HALF_W-1:0] data_i,
  input  logic                save_i,
  input  logic                restore_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [2*HALF_W-1:0] rd_data_o
);

  logic [HALF_W-1:0] lo_q [NUM_REGS];
  logic [HALF_W-1:0] hi_q [NUM_REGS];
  logic [HALF_W-1:0] sh_q [NUM_REGS];

  assign rd_data_o = {hi_q[rd_idx_i], lo_q[rd_idx_i]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
        sh_q[i] <= '0;
      end
    end else if (we_i) begin
      // bulk moves first, destination write below overrides
      for (int i = 0; i < NUM_REGS; i++) begin
        if (save_i) begin
          sh_q[i] <= hi_q[i];
          hi_q[i] <= '0;
        end
        if (restore_i)                 hi_q[i] <= sh_q[i];
        if (cls_i == OP_ZUP)           hi_q[i] <= '0;
        if (cls_i == OP_ZALL) begin
          hi_q[i] <= '0;
          lo_q[i] <= '0;
        end
      end
      unique case (cls_i)
        OP_LEG128: lo_q[dst_i] <= data_i[HALF_W-1:0];
        OP_VEX128: begin
          lo_q[dst_i] <= data_i[HALF_W-1:0];
          hi_q[dst_i] <= '0;
        end
        OP_VEX256: begin
          lo_q[dst_i] <= data_i[HALF_W-1:0];
          hi_q[dst_i] <= data_i[2*HALF_W-1:HALF_W];
        end
        default: ;
      endcase
    end
  end

  AST_SAVE_CLEARS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && save_i |=> hi_q[0] == '0 && hi_q[NUM_REGS-1] == '0); // R3
  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && save_i) |=> $stable(sh_q[0]) && $stable(sh_q[NUM_REGS-1])); // R6
  AST_ZALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cls_i == OP_ZALL |=> lo_q[0] == '0 && hi_q[0] == '0); // R8

endmodule

// File: rtl/vec_upper_tracker.sv
module vec_upper_tracker
  import vut_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned HALF_W   = 128,
  parameter int unsigned PENALTY  = 70,
  parameter int unsigned CNT_W    = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  output logic                op_ready_o,
  input  logic [2:0]          op_class_i,
  input  logic [IDX_W-1:0]    op_dst_i,
  input  logic [2*HALF_W-1:0] op_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [2*HALF_W-1:0] rd_data_o,
  output logic [1:0]          dbg_state_o,
  output logic [CNT_W-1:0]    dbg_penalty_cnt_o
);

  op_cls_e cls;
  ust_e    state;
  logic    accept, save, restore;

  assign cls         = op_cls_e'(op_class_i);
  assign dbg_state_o = state;

  vut_ctrl #(
    .PENALTY (PENALTY),
    .CNT_W   (CNT_W)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (op_valid_i),
    .cls_i     (cls),
    .ready_o   (op_ready_o),
    .accept_o  (accept),
    .save_o    (save),
    .restore_o (restore),
    .state_o   (state),
    .pen_cnt_o (dbg_penalty_cnt_o)
  );

  vut_regfile #(
    .NUM_REGS (NUM_REGS),
    .HALF_W   (HALF_W)
  ) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (accept),
    .cls_i     (cls),
    .dst_i     (op_dst_i),
    .data_i    (op_data_i),
    .save_i    (save),
    .restore_i (restore),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  AST_LEGAL_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> op_class_i <= 3'd4); // R12

endmodule

// File: tb/test_vec_upper_tracker.sv
module test_vec_upper_tracker;

  localparam int PEN = 70;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [2:0]   op_class = '0;
  logic [3:0]   op_dst = '0;
  logic [255:0] op_data = '0;
  logic [3:0]   rd_idx = '0;
  logic [255:0] rd_data;
  logic [1:0]   dbg_state;
  logic [31:0]  dbg_pen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [127:0] m_lo [16];
  logic [127:0] m_hi [16];
  logic [127:0] m_sh [16];
  int           m_st;
  int unsigned  m_pen;

  always #10 clk = ~clk;

  vec_upper_tracker #(.PENALTY(PEN)) i_vec_upper_tracker (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .op_valid_i        (op_valid),
    .op_ready_o        (op_ready),
    .op_class_i        (op_class),
    .op_dst_i          (op_dst),
    .op_data_i         (op_data),
    .rd_idx_i          (rd_idx),
    .rd_data_o         (rd_data),
    .dbg_state_o       (dbg_state),
    .dbg_penalty_cnt_o (dbg_pen)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic bit needs_pen(input int st, input int c);
    if (st == 1) return c == 0;
    if (st == 2) return c != 0;
    return 1'b0;
  endfunction

  function automatic string tag_of(input int st, input int c);
    case (c)
      0: return (st == 1) ? "R3" : "R4";
      1: return (st == 2) ? "R6" : "R5";
      2: return (st == 2) ? "R6" : "R2";
      3: return (st == 2) ? "R9" : "R7";
      default: return (st == 2) ? "R9" : "R8";
    endcase
  endfunction

  task automatic model_apply(input int c, input int d, input logic [255:0] data);
    case (c)
      0: begin
        if (m_st == 1) begin
          for (int i = 0; i < 16; i++) begin m_sh[i] = m_hi[i]; m_hi[i] = '0; end
          m_st = 2;
        end
        m_lo[d] = data[127:0];
      end
      1, 2: begin
        if (m_st == 2) begin
          for (int i = 0; i < 16; i++) m_hi[i] = m_sh[i];
          m_st = 1;
        end
        m_lo[d] = data[127:0];
        m_hi[d] = (c == 2) ? data[255:128] : '0;
        if (c == 2) m_st = 1;
      end
      3: begin
        for (int i = 0; i < 16; i++) m_hi[i] = '0;
        m_st = 0;
      end
      default: begin
        for (int i = 0; i < 16; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
        m_st = 0;
      end
    endcase
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rd_data == {m_hi[i], m_lo[i]}, tag, rd_data, {m_hi[i], m_lo[i]});
    end
  endtask

  task automatic issue(input int c, input int d, input logic [255:0] data);
    int    stalls;
    int    exp_stalls;
    string tag;
    tag        = tag_of(m_st, c);
    exp_stalls = needs_pen(m_st, c) ? PEN : 0;
    @(negedge clk);
    op_valid = 1'b1;
    op_class = 3'(c);
    op_dst   = 4'(d);
    op_data  = data;
    stalls   = 0;
    #1;
    while (!op_ready && stalls < 4 * PEN) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk(stalls == exp_stalls, {tag, " stall length"}, 256'(stalls), 256'(exp_stalls));
    if (exp_stalls == 0)
      chk(stalls == 0, "R12 immediate commit", 256'(stalls), 256'd0);
    model_apply(c, d, data);
    m_pen += exp_stalls;
    chk(dbg_state == 2'(m_st), {tag, " state"}, 256'(dbg_state), 256'(m_st));
    chk(dbg_pen == m_pen, "R11 penalty count", 256'(dbg_pen), 256'(m_pen));
    rd_idx = 4'(d);
    #1;
    chk(rd_data == {m_hi[d], m_lo[d]}, {tag, " dst data"}, rd_data, {m_hi[d], m_lo[d]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_sh[i] = '0; end
    m_st  = 0;
    m_pen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(dbg_state == 2'd0, "R1 reset state", 256'(dbg_state), 256'd0);
    chk(dbg_pen == 32'd0, "R1 reset penalty count", 256'(dbg_pen), 256'd0);
    chk(op_ready == 1'b1, "R1 reset ready", 256'(op_ready), 256'd1);
    sweep("R1 reset registers");

    // directed sequence across all transitions
    issue(0, 3, rnd256());                 // R4 legacy in clean
    issue(1, 4, rnd256());                 // R5 narrow vex in clean
    issue(2, 5, rnd256());                 // R2 wide from clean
    issue(2, 6, rnd256());
    v = rnd256(); v[255:128] = '0;
    issue(2, 7, v);                        // R10 zero upper via ordinary write keeps dirty
    chk(dbg_state == 2'd1, "R10 still dirty", 256'(dbg_state), 256'd1);
    issue(1, 8, rnd256());                 // R5 narrow vex in dirty
    issue(0, 5, rnd256());                 // R3 save to shadow
    sweep("R3 uppers parked");
    issue(0, 9, rnd256());                 // R4 legacy in parked
    issue(1, 2, rnd256());                 // R6 restore via narrow vex
    sweep("R6 uppers restored");
    issue(0, 1, rnd256());                 // R3 again
    issue(2, 11, rnd256());                // R6 restore via wide vex
    sweep("R6 wide restore");
    issue(3, 0, rnd256());                 // R7 zero upper from dirty
    sweep("R7 lowers kept");
    issue(2, 12, rnd256());
    issue(0, 13, rnd256());
    issue(3, 0, rnd256());                 // R9 zero upper from parked
    issue(2, 14, rnd256());
    issue(4, 0, rnd256());                 // R8 zero all from dirty
    sweep("R8 all cleared");
    issue(2, 15, rnd256());
    issue(0, 15, rnd256());
    issue(4, 0, rnd256());                 // R9 zero all from parked
    sweep("R9 after zero all");

    // constrained random mix
    for (int n = 0; n < 220; n++) begin
      int c;
      c = int'($urandom % 5);
      v = rnd256();
      if ($urandom % 4 == 0) v[255:128] = '0;
      issue(c, int'($urandom % 16), v);
      if (n % 20 == 19) sweep("R2 random sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule